// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block translates a virtual address to a physical address through a flat, one-level page table held in memory. A requester presents a virtual address together with the kind of access (load or store, user or supervisor) over a valid/ready handshake. The block splits the address into a page number and an in-page offset. It compares the page number with a per-process limit and, if the number is in range, fetches the single 32-bit entry that describes that page from the memory port. It then returns either a physical address or a fault code.

The table base address and the page-number limit form part of each process's context. Software reloads them through two write ports when it switches a process in. A reload that arrives while a translation is under way is parked and takes effect once the walker is idle again, so every walk sees one consistent context. Only one translation is handled at a time. The memory port accepts a read through its own valid/ready pair and answers after any number of cycles.

Entry layout used by the walker: bit 0 is the present flag, bit 1 allows stores, bit 2 allows user-mode access, and bits 31:12 carry the physical page number. Bits 11:3 are ignored.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: For an in-range page the walker issues exactly one memory read, at byte address `base + vpn*4`, where vpn is `req_vaddr[VA_W-1:PAGE_BITS]`.
- R3: A page number greater than the limit register returns fault code 1 (bounds) and issues no memory read. A page number equal to the limit is in range.
- R4: An entry with bit 0 clear returns fault code 2 (not present). On any fault `rsp_paddr` is 0.
- R5: A present entry returns fault code 3 (protection) for a store when bit 1 is clear, or for a user access when bit 2 is clear. Otherwise it returns fault code 0.
- R6: On success `rsp_paddr` is the entry's bits 31:12 concatenated with the unchanged low PAGE_BITS bits of the virtual address.
- R7: `rsp_valid` is high for exactly one cycle per translation, and `rsp_vaddr` echoes the requested virtual address.
- R8: `req_ready` is low from the cycle after a request is accepted until the cycle after its response, so only one translation is in flight.
- R9: A write to the base or limit register while a walk is in progress does not affect that walk. It takes effect for the next walk.
- R10: Fault priority: a bounds fault is raised before the entry is read, and a not-present fault outranks a protection fault.
- R11: The memory read request holds its address until the port accepts it, and the walker waits any number of cycles for the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_base_we | input | 1 | Load the table base register |
| ctx_base_wdata | input | MEM_AW (32) | New table base byte address |
| ctx_limit_we | input | 1 | Load the page-number limit register |
| ctx_limit_wdata | input | VPN_W (20) | New highest valid page number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | VA_W (32) | Virtual address to translate |
| req_is_store | input | 1 | 1 for a store access, 0 for a load |
| req_is_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MEM_AW (32) | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry contents |
| rsp_valid | output | 1 | Translation result, one-cycle pulse |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 not present, 3 protection |
| rsp_paddr | output | PA_W (32) | Physical address, 0 on a fault |
| rsp_vaddr | output | VA_W (32) | Virtual address of this result |

## Verification
The assertions assume that the memory port never returns read data unless a read is outstanding. They also assume that `mem_req_ready` is the only way a read gets accepted, and that reset is held for at least one clock edge. The bench's memory model meets these assumptions: it answers only reads it has accepted, and it pulses `mem_rsp_valid` a configurable number of cycles after each acceptance. Requests are presented only while the walker is idle. Context writes are issued both while idle and in the middle of a walk, to cover both paths into the registers.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CHECK    = 2'd1,
        ST_READ_PTE = 2'd2,
        ST_RESPOND  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BOUNDS = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PROT   = 2'd3
    } fault_e;

    localparam int PTE_W       = 32;
    localparam int PTE_SHIFT   = 2;   // log2 of entry size in bytes
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int PPN_LSB     = 12;

endpackage

// File: rtl/ptw_ctx_regs.sv
module ptw_ctx_regs #(
    parameter int MEM_AW = 32,
    parameter int VPN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    input  logic              limit_we,
    input  logic [VPN_W-1:0]  limit_wdata,
    output logic [MEM_AW-1:0] base_q,
    output logic [VPN_W-1:0]  limit_q
);

    typedef struct packed {
        logic [MEM_AW-1:0] base;
        logic [VPN_W-1:0]  limit;
        logic [MEM_AW-1:0] held_base;
        logic              held_base_vld;
        logic [VPN_W-1:0]  held_limit;
        logic              held_limit_vld;
    } ctx_s;

    ctx_s ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (busy) begin
            if (base_we) begin
                ctx_d.held_base     = base_wdata;
                ctx_d.held_base_vld = 1'b1;
            end
            if (limit_we) begin
                ctx_d.held_limit     = limit_wdata;
                ctx_d.held_limit_vld = 1'b1;
            end
        end else begin
            if (ctx_q.held_base_vld) begin
                ctx_d.base          = ctx_q.held_base;
                ctx_d.held_base_vld = 1'b0;
            end
            if (ctx_q.held_limit_vld) begin
                ctx_d.limit          = ctx_q.held_limit;
                ctx_d.held_limit_vld = 1'b0;
            end
            if (base_we) begin
                ctx_d.base = base_wdata;
            end
            if (limit_we) begin
                ctx_d.limit = limit_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign base_q  = ctx_q.base;
    assign limit_q = ctx_q.limit;

    // R9: context used by a walk never moves while the walk is running
    a_r9_base_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q));
    a_r9_limit_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(limit_q));

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int PPN_W = 20
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_store,
    input  logic             is_user,
    output fault_e           fault,
    output logic [PPN_W-1:0] ppn
);

    logic present, writable, user_ok;
    logic unused_pte_bits;

    assign present  = pte[BIT_PRESENT];
    assign writable = pte[BIT_WRITE];
    assign user_ok  = pte[BIT_USER];
    assign ppn      = pte[PPN_LSB +: PPN_W];
    assign unused_pte_bits = ^pte[PPN_LSB-1:BIT_USER+1];

    // R10: absence outranks permission checks
    always_comb begin
        if (!present) begin
            fault = FLT_ABSENT;
        end else if ((is_store && !writable) || (is_user && !user_ok)) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 20,
    parameter int MEM_AW    = 32,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_is_store,
    input  logic              req_is_user,
    input  logic [MEM_AW-1:0] base,
    input  logic [VPN_W-1:0]  limit,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              cur_is_store,
    output logic              cur_is_user,
    input  fault_e            pte_fault,
    input  logic [PPN_W-1:0]  pte_ppn,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [VA_W-1:0]   rsp_vaddr
);

    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  va;
        logic             is_store;
        logic             is_user;
        logic             issued;
        fault_e           flt;
        logic [PA_W-1:0]  pa;
    } walk_s;

    walk_s walk_d, walk_q;

    logic [VPN_W-1:0]     cur_vpn;
    logic [PAGE_BITS-1:0] cur_off;
    logic                 out_of_range;

    assign cur_vpn      = walk_q.va[VA_W-1:PAGE_BITS];
    assign cur_off      = walk_q.va[PAGE_BITS-1:0];
    assign out_of_range = cur_vpn > limit;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.st       = ST_CHECK;
                    walk_d.va       = req_vaddr;
                    walk_d.is_store = req_is_store;
                    walk_d.is_user  = req_is_user;
                    walk_d.flt      = FLT_NONE;
                    walk_d.pa       = '0;
                end
            end
            ST_CHECK: begin
                if (out_of_range) begin
                    walk_d.flt = FLT_BOUNDS;
                    walk_d.st  = ST_RESPOND;
                end else begin
                    walk_d.issued = 1'b0;
                    walk_d.st     = ST_READ_PTE;
                end
            end
            ST_READ_PTE: begin
                if (!walk_q.issued && mem_req_ready) begin
                    walk_d.issued = 1'b1;
                end
                if (walk_q.issued && mem_rsp_valid) begin
                    walk_d.flt = pte_fault;
                    walk_d.pa  = (pte_fault == FLT_NONE) ? {pte_ppn, cur_off} : '0;
                    walk_d.st  = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                walk_d.st = ST_IDLE;
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.st == ST_IDLE);
    assign busy          = (walk_q.st != ST_IDLE);
    assign mem_req_valid = (walk_q.st == ST_READ_PTE) && !walk_q.issued;
    assign mem_req_addr  = base + (MEM_AW'(cur_vpn) << PTE_SHIFT);
    assign cur_is_store  = walk_q.is_store;
    assign cur_is_user   = walk_q.is_user;
    assign rsp_valid     = (walk_q.st == ST_RESPOND);
    assign rsp_fault     = walk_q.flt;
    assign rsp_paddr     = walk_q.pa;
    assign rsp_vaddr     = walk_q.va;

    // R8: one translation at a time
    a_r8_single_flight : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7: result is a single-cycle pulse
    a_r7_rsp_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11: read request held steady until accepted
    a_r11_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R3: out-of-range page never reaches the memory port
    a_r3_no_read_oob : assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.st == ST_CHECK && out_of_range) |=> !mem_req_valid);
    // R4: faulting result carries no address
    a_r4_fault_zero_pa : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
    // R6: offset passes through untouched
    a_r6_offset_kept : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |->
            (rsp_paddr[PAGE_BITS-1:0] == rsp_vaddr[PAGE_BITS-1:0]));

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 20,
    parameter int MEM_AW    = 32,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_base_we,
    input  logic [MEM_AW-1:0] ctx_base_wdata,
    input  logic              ctx_limit_we,
    input  logic [VPN_W-1:0]  ctx_limit_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_is_store,
    input  logic              req_is_user,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [VA_W-1:0]   rsp_vaddr
);

    logic              busy;
    logic [MEM_AW-1:0] base_q;
    logic [VPN_W-1:0]  limit_q;
    logic              cur_is_store, cur_is_user;
    fault_e            pte_fault;
    logic [PPN_W-1:0]  pte_ppn;

    ptw_ctx_regs #(
        .MEM_AW (MEM_AW),
        .VPN_W  (VPN_W)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .base_we     (ctx_base_we),
        .base_wdata  (ctx_base_wdata),
        .limit_we    (ctx_limit_we),
        .limit_wdata (ctx_limit_wdata),
        .base_q      (base_q),
        .limit_q     (limit_q)
    );

    ptw_pte_check #(
        .PPN_W (PPN_W)
    ) u_pte (
        .pte      (mem_rsp_data),
        .is_store (cur_is_store),
        .is_user  (cur_is_user),
        .fault    (pte_fault),
        .ppn      (pte_ppn)
    );

    ptw_walk_fsm #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PPN_W     (PPN_W),
        .MEM_AW    (MEM_AW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_is_store  (req_is_store),
        .req_is_user   (req_is_user),
        .base          (base_q),
        .limit         (limit_q),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .cur_is_store  (cur_is_store),
        .cur_is_user   (cur_is_user),
        .pte_fault     (pte_fault),
        .pte_ppn       (pte_ppn),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr),
        .rsp_vaddr     (rsp_vaddr)
    );

    // R1: idle outputs right after reset
    a_r1_reset_idle : assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_req_valid));

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_base_we = 1'b0;
    logic [31:0] ctx_base_wdata = '0;
    logic        ctx_limit_we = 1'b0;
    logic [19:0] ctx_limit_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_is_store = 1'b0;
    logic        req_is_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_vaddr;

    ptw_walker u_dut (
        .clk (clk), .rst_n (rst_n),
        .ctx_base_we (ctx_base_we), .ctx_base_wdata (ctx_base_wdata),
        .ctx_limit_we (ctx_limit_we), .ctx_limit_wdata (ctx_limit_wdata),
        .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
        .req_is_store (req_is_store), .req_is_user (req_is_user),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data), .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault), .rsp_paddr (rsp_paddr), .rsp_vaddr (rsp_vaddr)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mem [256];
    int          m_lat = 1;
    int          m_stall = 0;
    int          m_reads = 0;
    logic [31:0] m_last_addr = '0;

    // behavioural entry memory
    initial begin
        int cnt;
        logic [31:0] pend;
        cnt = 0;
        pend = '0;
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[pend[9:2]];
                end
            end
            if (mem_req_valid) begin
                if (m_stall > 0) begin
                    mem_req_ready = 1'b0;
                    m_stall--;
                end else begin
                    mem_req_ready = 1'b1;
                    m_reads++;
                    m_last_addr = mem_req_addr;
                    pend = mem_req_addr;
                    cnt = m_lat;
                end
            end else begin
                mem_req_ready = 1'b1;
            end
        end
    end

    function automatic logic [31:0] mkpte(input logic [19:0] ppn, input bit v, w, u);
        return {ppn, 9'd0, u, w, v};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [31:0] b, input logic [19:0] l);
        @(negedge clk);
        ctx_base_we = 1'b1; ctx_base_wdata = b;
        ctx_limit_we = 1'b1; ctx_limit_wdata = l;
        @(negedge clk);
        ctx_base_we = 1'b0; ctx_limit_we = 1'b0;
    endtask

    logic [1:0]  g_fault;
    logic [31:0] g_pa, g_va;
    bit          g_ready_bad, g_pulse_bad;

    task automatic walk(input logic [31:0] va, input bit st, input bit usr,
                        input int lat, input int stall,
                        input bit wr_ctx, input logic [31:0] nb, input logic [19:0] nl);
        int n;
        m_lat = lat; m_stall = stall; m_reads = 0;
        g_ready_bad = 1'b0; g_pulse_bad = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_is_store = st; req_is_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr_ctx) begin
            ctx_base_we = 1'b1; ctx_base_wdata = nb;
            ctx_limit_we = 1'b1; ctx_limit_wdata = nl;
        end
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) g_ready_bad = 1'b1;
            @(negedge clk);
            ctx_base_we = 1'b0; ctx_limit_we = 1'b0;
            n++;
        end
        ctx_base_we = 1'b0; ctx_limit_we = 1'b0;
        g_fault = rsp_fault; g_pa = rsp_paddr; g_va = rsp_vaddr;
        if (!rsp_valid || req_ready) g_ready_bad = 1'b1;
        @(negedge clk);
        if (rsp_valid) g_pulse_bad = 1'b1;
        if (!req_ready) g_ready_bad = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_basic;
        set_ctx(32'h100, 20'd15);
        mem[64+3] = mkpte(20'hABCDE, 1, 1, 1);
        walk({20'd3, 12'h5A4}, 1, 1, 1, 0, 0, '0, '0);
        chk("R2", "entry address", m_last_addr, 32'h10C);
        chk("R2", "read count", m_reads, 32'd1);
        chk("R6", "paddr", g_pa, 32'hABCDE5A4);
        chk("R5", "fault none", {30'd0, g_fault}, 32'd0);
        chk("R7", "vaddr echo", g_va, {20'd3, 12'h5A4});
        chk("R7", "single pulse", {31'd0, g_pulse_bad}, 32'd0);
        chk("R8", "ready low during walk", {31'd0, g_ready_bad}, 32'd0);
    endtask

    task automatic t_latency;
        mem[64+5] = mkpte(20'h12345, 1, 0, 0);
        walk({20'd5, 12'hFFF}, 0, 0, 6, 3, 0, '0, '0);
        chk("R11", "paddr after slow memory", g_pa, 32'h12345FFF);
        chk("R11", "read count", m_reads, 32'd1);
        chk("R11", "entry address held", m_last_addr, 32'h114);
        chk("R8", "ready low during slow walk", {31'd0, g_ready_bad}, 32'd0);
    endtask

    task automatic t_bounds;
        mem[64+15] = mkpte(20'h00F0F, 1, 1, 1);
        walk({20'd15, 12'h001}, 0, 1, 2, 0, 0, '0, '0);
        chk("R3", "limit page in range", {30'd0, g_fault}, 32'd0);
        chk("R3", "limit page paddr", g_pa, 32'h00F0F001);
        walk({20'd16, 12'h001}, 0, 1, 2, 0, 0, '0, '0);
        chk("R3", "bounds fault code", {30'd0, g_fault}, 32'd1);
        chk("R3", "no read on bounds", m_reads, 32'd0);
        chk("R4", "bounds paddr zero", g_pa, 32'd0);
        walk({20'hFFFFF, 12'h000}, 1, 1, 2, 0, 0, '0, '0);
        chk("R10", "bounds before entry", {30'd0, g_fault}, 32'd1);
        chk("R7", "bounds vaddr echo", g_va, 32'hFFFFF000);
    endtask

    task automatic t_absent;
        mem[64+7] = mkpte(20'h77777, 0, 1, 1);
        walk({20'd7, 12'h010}, 0, 0, 1, 0, 0, '0, '0);
        chk("R4", "not present code", {30'd0, g_fault}, 32'd2);
        chk("R4", "not present paddr", g_pa, 32'd0);
        mem[64+8] = mkpte(20'h88888, 0, 0, 0);
        walk({20'd8, 12'h010}, 1, 1, 1, 0, 0, '0, '0);
        chk("R10", "absent outranks protection", {30'd0, g_fault}, 32'd2);
    endtask

    task automatic t_prot;
        mem[64+9] = mkpte(20'h99999, 1, 0, 1);
        walk({20'd9, 12'h020}, 1, 1, 1, 0, 0, '0, '0);
        chk("R5", "store to read-only", {30'd0, g_fault}, 32'd3);
        chk("R4", "protection paddr zero", g_pa, 32'd0);
        mem[64+10] = mkpte(20'hAAAAA, 1, 1, 0);
        walk({20'd10, 12'h020}, 0, 1, 1, 0, 0, '0, '0);
        chk("R5", "user to supervisor page", {30'd0, g_fault}, 32'd3);
        mem[64+11] = mkpte(20'hBBBBB, 1, 0, 0);
        walk({20'd11, 12'h321}, 0, 0, 1, 0, 0, '0, '0);
        chk("R5", "supervisor load ok", {30'd0, g_fault}, 32'd0);
        chk("R6", "supervisor load paddr", g_pa, 32'hBBBBB321);
    endtask

    task automatic t_hold;
        mem[64+12] = mkpte(20'h0CCCC, 1, 1, 1);
        mem[128+1] = mkpte(20'h0DDDD, 1, 1, 1);
        walk({20'd12, 12'h444}, 0, 0, 4, 0, 1, 32'h200, 20'd2);
        chk("R9", "walk keeps old base", m_last_addr, 32'h130);
        chk("R9", "walk keeps old limit", {30'd0, g_fault}, 32'd0);
        walk({20'd1, 12'h555}, 0, 0, 1, 0, 0, '0, '0);
        chk("R9", "next walk uses new base", m_last_addr, 32'h204);
        chk("R9", "next walk paddr", g_pa, 32'h0DDDD555);
        walk({20'd3, 12'h000}, 0, 0, 1, 0, 0, '0, '0);
        chk("R9", "next walk uses new limit", {30'd0, g_fault}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_latency();
        t_bounds();
        t_absent();
        t_prot();
        t_hold();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule